// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control words reached through a plain word-wide register bus: a write strobe, a read strobe, a byte address, write data and read data. A guard word protects part of the bank. Writing the unlock constant to the guard word opens the bank. Writing any other value closes it again. A write to a guarded word while the bank is closed still lands, but it is reported as a locked-write error.

Several identification and status words are read-only. Their values come from input ports, because the logic that produces them lives elsewhere. Writes to these words are refused and reported. One word holds hardware strap bits. The `NEWER_MODE` parameter selects how it behaves:
- In the newer mode, a write to the strap word only sets bits. A write to the revision word does not change the revision; it clears the strap bits that are 1 in the data.
- In the older mode, a write to the strap word replaces it, and the revision word is read-only like the other status words.

Any bad access produces a one-cycle error pulse carrying a 2-bit cause code.

Top module: `keyed_ctl_bank`

## Requirements
- R1: A write to the guard word (slot `KEY_IDX`, byte address 0x000) stores 1 when the data equals `UNLOCK_KEY` (default 0x1688A8A8) and stores 0 for any other data. Reading the guard word returns this flag in bit 0, with the upper bits 0. A guard-word write never raises an error.
- R2: The guarded slots are those above `KEY_IDX` and below `LOCK_HI_IDX`. A write to a writable guarded slot while the flag is 0 is applied, and it raises error code 3 (locked). The same write with the flag at 1 raises no error. A write to a slot at or above `LOCK_HI_IDX` never raises the locked code.
- R3: Writes to the following read-only slots change nothing and raise error code 2 (read-only), even when the bank is locked:
  - the frequency-evaluation slot
  - the eight scratch slots
  - the random-data slot
  - the free-counter low and high slots
- R4: In the newer mode, a write to the strap slot ORs the data into the strap word.
- R5: In the newer mode, a write to the revision slot clears each strap bit that is 1 in the data. The revision read value stays equal to its input port.
- R6: In the older mode, a write to the strap slot replaces the strap word. A write to the revision slot leaves the strap word unchanged and raises error code 2.
- R7: A write whose slot index (byte address >> 2) is at or beyond `REG_COUNT`, or whose address has bits [1:0] nonzero, changes nothing and raises error code 1 (range). A read with the read strobe set to such an address returns 0 and raises code 1.
- R8: Read data is combinational from the address in the same cycle. Read-only slots return their input port values live.
- R9: Reset clears the guard flag to 0 (locked), loads the strap word with `STRAP_RESET`, loads every other stored word with 0, and holds the error output idle.
- R10: The error output is valid for exactly the one cycle after the access edge. The code is 0 when the output is not valid, and the output is never valid without an access on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (used only for error reporting) |
| addr | input | ADDR_W | Byte address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data |
| revIn | input | DATA_W | Revision identification word |
| freqIn | input | DATA_W | Frequency-evaluation status word |
| scratchIn | input | SCRATCH_N*DATA_W | Scratch words, word k at bits [k*DATA_W +: DATA_W] |
| rngIn | input | DATA_W | Random-data word |
| cntLoIn | input | DATA_W | Free counter, low word |
| cntHiIn | input | DATA_W | Free counter, high word |
| errValid | output | 1 | Error pulse |
| errCode | output | 2 | 1 range, 2 read-only, 3 locked, 0 none |

## Verification
A wrong guard flag shows in two ways:
- A read of slot 0 returns the wrong value at once.
- A guarded write raises the wrong error code on the very next cycle.

A strap word that has been corrupted, or a read-only slot that has wrongly been written, is caught by a read-back in the same cycle as the address is presented. Error pulses are compared one cycle after each access edge, so a missing pulse, a pulse that lingers, or a wrong priority between range, read-only and locked is caught at that cycle. Both variants are instantiated, so mode-dependent behaviour of the strap word is compared side by side.

// File: rtl/keyed_ctl_pkg.sv
package keyed_ctl_pkg;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_RANGE    = 2'd1,
    ERR_READONLY = 2'd2,
    ERR_LOCKED   = 2'd3
  } errCode_e;

  typedef enum logic [3:0] {
    RD_ZERO, RD_KEY, RD_STORE, RD_REV, RD_FREQ,
    RD_SCRATCH, RD_RNG, RD_CNTLO, RD_CNTHI
  } rdSel_e;

  // Strobes from the decoder to the storage datapath
  typedef struct packed {
    logic   storeEn;
    logic   keyWrite;
    logic   strapSet;
    logic   strapClear;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/keyed_ctl_decode.sv
module keyed_ctl_decode
  import keyed_ctl_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int REG_COUNT    = 64,
  parameter int KEY_IDX      = 0,
  parameter int LOCK_HI_IDX  = 32,
  parameter int STRAP_IDX    = 28,
  parameter int REV_IDX      = 31,
  parameter int FREQ_IDX     = 9,
  parameter int SCRATCH_BASE = 40,
  parameter int SCRATCH_N    = 8,
  parameter int RNG_IDX      = 50,
  parameter int CNT_LO_IDX   = 52,
  parameter int CNT_HI_IDX   = 53,
  parameter bit NEWER_MODE   = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         keyFlag,
  output ctlStrobe_t                   strobe,
  output logic [$clog2(REG_COUNT)-1:0] wordIdx,
  output logic [$clog2(SCRATCH_N)-1:0] scratchIdx,
  output logic                         errValid,
  output errCode_e                     errCode
);

  localparam int SLOT_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(REG_COUNT);
  localparam int SCR_W  = $clog2(SCRATCH_N);
  localparam logic [SLOT_W:0]   COUNT_LIM = (SLOT_W + 1)'(REG_COUNT);
  localparam logic [SLOT_W-1:0] KEY_S     = SLOT_W'(KEY_IDX);
  localparam logic [SLOT_W-1:0] LOCKHI_S  = SLOT_W'(LOCK_HI_IDX);
  localparam logic [SLOT_W-1:0] STRAP_S   = SLOT_W'(STRAP_IDX);
  localparam logic [SLOT_W-1:0] REV_S     = SLOT_W'(REV_IDX);
  localparam logic [SLOT_W-1:0] FREQ_S    = SLOT_W'(FREQ_IDX);
  localparam logic [SLOT_W-1:0] SCR_LO_S  = SLOT_W'(SCRATCH_BASE);
  localparam logic [SLOT_W-1:0] SCR_HI_S  = SLOT_W'(SCRATCH_BASE + SCRATCH_N - 1);
  localparam logic [SLOT_W-1:0] RNG_S     = SLOT_W'(RNG_IDX);
  localparam logic [SLOT_W-1:0] CLO_S     = SLOT_W'(CNT_LO_IDX);
  localparam logic [SLOT_W-1:0] CHI_S     = SLOT_W'(CNT_HI_IDX);

  logic [SLOT_W-1:0] slot;
  logic              inRange, isKey, isScratch, isRo, inLock, revRo;
  errCode_e          errNext;

  assign slot       = addr[ADDR_W-1:2];
  assign inRange    = (addr[1:0] == 2'b00) && ({1'b0, slot} < COUNT_LIM);
  assign isKey      = slot == KEY_S;
  assign isScratch  = (slot >= SCR_LO_S) && (slot <= SCR_HI_S);
  assign inLock     = (slot > KEY_S) && (slot < LOCKHI_S);
  assign wordIdx    = slot[IDX_W-1:0];
  assign scratchIdx = slot[SCR_W-1:0] - SCR_W'(SCRATCH_BASE);

  // Variant pick: the revision slot is a plain read-only word only in older mode
  generate
    if (NEWER_MODE) begin : g_newRev
      assign revRo = 1'b0;
    end else begin : g_oldRev
      assign revRo = 1'b1;
    end
  endgenerate

  assign isRo = (revRo && slot == REV_S) || slot == FREQ_S || isScratch ||
                slot == RNG_S || slot == CLO_S || slot == CHI_S;

  // Write decode
  always_comb begin
    strobe.storeEn    = 1'b0;
    strobe.keyWrite   = 1'b0;
    strobe.strapSet   = 1'b0;
    strobe.strapClear = 1'b0;
    errNext           = ERR_NONE;
    if (wrEn) begin
      if (!inRange) begin
        errNext = ERR_RANGE;
      end else if (isKey) begin
        strobe.keyWrite = 1'b1;
      end else if (isRo) begin
        errNext = ERR_READONLY;
      end else begin
        if (inLock && !keyFlag) errNext = ERR_LOCKED;
        if (NEWER_MODE && slot == STRAP_S)    strobe.strapSet   = 1'b1;
        else if (NEWER_MODE && slot == REV_S) strobe.strapClear = 1'b1;
        else                                  strobe.storeEn    = 1'b1;
      end
    end
    if (errNext == ERR_NONE && rdEn && !inRange) errNext = ERR_RANGE;
  end

  // Read select
  always_comb begin
    if (!inRange)            strobe.rdSel = RD_ZERO;
    else if (isKey)          strobe.rdSel = RD_KEY;
    else if (slot == REV_S)  strobe.rdSel = RD_REV;
    else if (slot == FREQ_S) strobe.rdSel = RD_FREQ;
    else if (isScratch)      strobe.rdSel = RD_SCRATCH;
    else if (slot == RNG_S)  strobe.rdSel = RD_RNG;
    else if (slot == CLO_S)  strobe.rdSel = RD_CNTLO;
    else if (slot == CHI_S)  strobe.rdSel = RD_CNTHI;
    else                     strobe.rdSel = RD_STORE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      errValid <= errNext != ERR_NONE;
      errCode  <= errNext;
    end
  end

endmodule

// File: rtl/keyed_ctl_store.sv
module keyed_ctl_store
  import keyed_ctl_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          REG_COUNT   = 64,
  parameter int          STRAP_IDX   = 28,
  parameter int          SCRATCH_N   = 8,
  parameter logic [31:0] UNLOCK_KEY  = 32'h1688_A8A8,
  parameter logic [31:0] STRAP_RESET = 32'h0000_F0C3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strobe,
  input  logic [$clog2(REG_COUNT)-1:0]  wordIdx,
  input  logic [$clog2(SCRATCH_N)-1:0]  scratchIdx,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [DATA_W-1:0]             revIn,
  input  logic [DATA_W-1:0]             freqIn,
  input  logic [SCRATCH_N*DATA_W-1:0]   scratchIn,
  input  logic [DATA_W-1:0]             rngIn,
  input  logic [DATA_W-1:0]             cntLoIn,
  input  logic [DATA_W-1:0]             cntHiIn,
  output logic [DATA_W-1:0]             rdData,
  output logic                          keyFlag,
  output logic [DATA_W-1:0]             strapWord
);

  localparam logic [DATA_W-1:0] KEY_VAL    = DATA_W'(UNLOCK_KEY);
  localparam logic [DATA_W-1:0] STRAP_INIT = DATA_W'(STRAP_RESET);

  logic [DATA_W-1:0] words [REG_COUNT];

  function automatic logic [DATA_W-1:0] resetWord(int idx);
    return (idx == STRAP_IDX) ? STRAP_INIT : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyFlag <= 1'b0;
      for (int i = 0; i < REG_COUNT; i++) words[i] <= resetWord(i);
    end else begin
      if (strobe.keyWrite)   keyFlag <= (wrData == KEY_VAL);
      if (strobe.storeEn)    words[wordIdx] <= wrData;
      if (strobe.strapSet)   words[STRAP_IDX] <= words[STRAP_IDX] | wrData;
      if (strobe.strapClear) words[STRAP_IDX] <= words[STRAP_IDX] & ~wrData;
    end
  end

  assign strapWord = words[STRAP_IDX];

  always_comb begin
    unique case (strobe.rdSel)
      RD_KEY:     rdData = {{(DATA_W-1){1'b0}}, keyFlag};
      RD_STORE:   rdData = words[wordIdx];
      RD_REV:     rdData = revIn;
      RD_FREQ:    rdData = freqIn;
      RD_SCRATCH: rdData = scratchIn[scratchIdx*DATA_W +: DATA_W];
      RD_RNG:     rdData = rngIn;
      RD_CNTLO:   rdData = cntLoIn;
      RD_CNTHI:   rdData = cntHiIn;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/keyed_ctl_bank.sv
module keyed_ctl_bank
  import keyed_ctl_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter int          DATA_W       = 32,
  parameter int          REG_COUNT    = 64,
  parameter int          KEY_IDX      = 0,
  parameter int          LOCK_HI_IDX  = 32,
  parameter int          STRAP_IDX    = 28,
  parameter int          REV_IDX      = 31,
  parameter int          FREQ_IDX     = 9,
  parameter int          SCRATCH_BASE = 40,
  parameter int          SCRATCH_N    = 8,
  parameter int          RNG_IDX      = 50,
  parameter int          CNT_LO_IDX   = 52,
  parameter int          CNT_HI_IDX   = 53,
  parameter logic [31:0] UNLOCK_KEY   = 32'h1688_A8A8,
  parameter logic [31:0] STRAP_RESET  = 32'h0000_F0C3,
  parameter bit          NEWER_MODE   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  input  logic [DATA_W-1:0]           revIn,
  input  logic [DATA_W-1:0]           freqIn,
  input  logic [SCRATCH_N*DATA_W-1:0] scratchIn,
  input  logic [DATA_W-1:0]           rngIn,
  input  logic [DATA_W-1:0]           cntLoIn,
  input  logic [DATA_W-1:0]           cntHiIn,
  output logic                        errValid,
  output logic [1:0]                  errCode
);

  localparam int IDX_W = $clog2(REG_COUNT);
  localparam int SCR_W = $clog2(SCRATCH_N);

  ctlStrobe_t        strobe;
  logic [IDX_W-1:0]  wordIdx;
  logic [SCR_W-1:0]  scratchIdx;
  logic              keyFlag;
  logic [DATA_W-1:0] strapWord;
  errCode_e          errCodeE;

  keyed_ctl_decode #(
    .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT), .KEY_IDX(KEY_IDX),
    .LOCK_HI_IDX(LOCK_HI_IDX), .STRAP_IDX(STRAP_IDX), .REV_IDX(REV_IDX),
    .FREQ_IDX(FREQ_IDX), .SCRATCH_BASE(SCRATCH_BASE), .SCRATCH_N(SCRATCH_N),
    .RNG_IDX(RNG_IDX), .CNT_LO_IDX(CNT_LO_IDX), .CNT_HI_IDX(CNT_HI_IDX),
    .NEWER_MODE(NEWER_MODE)
  ) decode_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .keyFlag(keyFlag), .strobe(strobe), .wordIdx(wordIdx),
    .scratchIdx(scratchIdx), .errValid(errValid), .errCode(errCodeE)
  );

  keyed_ctl_store #(
    .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .STRAP_IDX(STRAP_IDX),
    .SCRATCH_N(SCRATCH_N), .UNLOCK_KEY(UNLOCK_KEY), .STRAP_RESET(STRAP_RESET)
  ) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .scratchIdx(scratchIdx), .wrData(wrData), .revIn(revIn), .freqIn(freqIn),
    .scratchIn(scratchIn), .rngIn(rngIn), .cntLoIn(cntLoIn), .cntHiIn(cntHiIn),
    .rdData(rdData), .keyFlag(keyFlag), .strapWord(strapWord)
  );

  assign errCode = errCodeE;

endmodule

// File: rtl/keyed_ctl_bank_checker.sv
module keyed_ctl_bank_checker #(
  parameter int          ADDR_W     = 10,
  parameter int          DATA_W     = 32,
  parameter int          KEY_IDX    = 0,
  parameter int          STRAP_IDX  = 28,
  parameter int          REV_IDX    = 31,
  parameter int          RNG_IDX    = 50,
  parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8,
  parameter bit          NEWER_MODE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              errValid,
  input logic [1:0]        errCode,
  input logic              keyFlag,
  input logic [DATA_W-1:0] strapWord
);

  localparam logic [ADDR_W-1:0] KEY_A   = ADDR_W'(KEY_IDX * 4);
  localparam logic [ADDR_W-1:0] STRAP_A = ADDR_W'(STRAP_IDX * 4);
  localparam logic [ADDR_W-1:0] REV_A   = ADDR_W'(REV_IDX * 4);
  localparam logic [ADDR_W-1:0] RNG_A   = ADDR_W'(RNG_IDX * 4);
  localparam logic [DATA_W-1:0] KEY_VAL = DATA_W'(UNLOCK_KEY);

  // R1: the guard flag follows the key comparison
  p_key_flag_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == KEY_A) |=> (keyFlag == ($past(wrData) == KEY_VAL)));

  // R3: a random-data write is refused with the read-only code
  p_ro_reject_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == RNG_A) |=> (errValid && errCode == 2'd2));

  // R4: a strap write in newer mode sets the data bits and clears none
  p_strap_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (NEWER_MODE && wrEn && addr == STRAP_A) |=>
      (((strapWord & $past(wrData)) == $past(wrData)) &&
       (($past(strapWord) & ~strapWord) == '0)));

  // R5: a revision write in newer mode clears the data bits
  p_strap_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (NEWER_MODE && wrEn && addr == REV_A) |=> ((strapWord & $past(wrData)) == '0));

  // R6: a revision write in older mode is refused and leaves the strap word alone
  p_old_rev_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!NEWER_MODE && wrEn && addr == REV_A) |=>
      ($stable(strapWord) && errValid && errCode == 2'd2));

  // R10: an error pulse always follows an access and carries a nonzero code
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> ($past(wrEn || rdEn) && errCode != 2'd0));

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |-> (errCode == 2'd0));

endmodule

bind keyed_ctl_bank keyed_ctl_bank_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_IDX(KEY_IDX), .STRAP_IDX(STRAP_IDX),
  .REV_IDX(REV_IDX), .RNG_IDX(RNG_IDX), .UNLOCK_KEY(UNLOCK_KEY),
  .NEWER_MODE(NEWER_MODE)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .errValid(errValid), .errCode(errCode),
  .keyFlag(keyFlag), .strapWord(strapWord)
);

// File: tb/keyed_ctl_bank_tb_top.sv
module keyed_ctl_bank_tb_top;

  localparam logic [31:0] REV_V   = 32'h0402_0303;
  localparam logic [31:0] FREQ_V  = 32'h0000_1234;
  localparam logic [31:0] RNG_V   = 32'hDEAD_BEEF;
  localparam logic [31:0] CLO_V   = 32'h0000_ABCD;
  localparam logic [31:0] CHI_V   = 32'h0000_0012;
  localparam logic [31:0] KEY_V   = 32'h1688_A8A8;
  localparam logic [2:0]  E_NONE  = 3'b000;
  localparam logic [2:0]  E_RANGE = 3'b101;
  localparam logic [2:0]  E_RO    = 3'b110;
  localparam logic [2:0]  E_LOCK  = 3'b111;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [2:0]  err;
    logic [9:0]  rdAddr;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{4'd2,  1'b1, 10'h014, 32'hAAAA_5555, E_LOCK, 10'h014, 32'hAAAA_5555}, // R2 locked write lands
    '{4'd1,  1'b1, 10'h000, 32'h1234_5678, E_NONE, 10'h000, 32'h0000_0000}, // R1 wrong key
    '{4'd1,  1'b1, 10'h000, KEY_V,         E_NONE, 10'h000, 32'h0000_0001}, // R1 unlock
    '{4'd2,  1'b1, 10'h014, 32'h0F0F_0F0F, E_NONE, 10'h014, 32'h0F0F_0F0F}, // R2 unlocked write
    '{4'd4,  1'b1, 10'h070, 32'h0000_0300, E_NONE, 10'h070, 32'h0000_F3C3}, // R4 strap OR
    '{4'd5,  1'b1, 10'h07C, 32'h0000_00C1, E_NONE, 10'h070, 32'h0000_F302}, // R5 strap clear
    '{4'd5,  1'b1, 10'h07C, 32'h0000_0000, E_NONE, 10'h07C, REV_V},         // R5 revision intact
    '{4'd3,  1'b1, 10'h0C8, 32'h0000_0001, E_RO,   10'h0C8, RNG_V},         // R3 random word
    '{4'd3,  1'b1, 10'h0AC, 32'h0000_0000, E_RO,   10'h0AC, 32'h5C00_0003}, // R3 scratch 3
    '{4'd3,  1'b1, 10'h024, 32'hFFFF_FFFF, E_RO,   10'h024, FREQ_V},        // R3 freq word
    '{4'd3,  1'b1, 10'h0D4, 32'h7777_7777, E_RO,   10'h0D4, CHI_V},         // R3 counter high
    '{4'd7,  1'b1, 10'h100, 32'h0000_0005, E_RANGE,10'h100, 32'h0000_0000}, // R7 beyond count
    '{4'd7,  1'b1, 10'h016, 32'hFFFF_FFFF, E_RANGE,10'h014, 32'h0F0F_0F0F}, // R7 misaligned
    '{4'd1,  1'b1, 10'h000, 32'h0000_0000, E_NONE, 10'h000, 32'h0000_0000}, // R1 relock
    '{4'd2,  1'b1, 10'h08C, 32'h1122_3344, E_NONE, 10'h08C, 32'h1122_3344}, // R2 outside guarded span
    '{4'd2,  1'b1, 10'h070, 32'h0000_0001, E_LOCK, 10'h070, 32'h0000_F303}  // R2/R4 locked strap
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic        errValid;
  logic [1:0]  errCode;
  logic [31:0] rngIn = RNG_V;
  logic [255:0] scratchIn;

  logic        oWrEn = 1'b0;
  logic [9:0]  oAddr = '0;
  logic [31:0] oWrData = '0, oRdData;
  logic        oErrValid;
  logic [1:0]  oErrCode;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always_comb
    for (int k = 0; k < 8; k++) scratchIn[k*32 +: 32] = 32'h5C00_0000 | 32'(k);

  keyed_ctl_bank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .revIn(REV_V), .freqIn(FREQ_V),
    .scratchIn(scratchIn), .rngIn(rngIn), .cntLoIn(CLO_V), .cntHiIn(CHI_V),
    .errValid(errValid), .errCode(errCode)
  );

  keyed_ctl_bank #(.NEWER_MODE(1'b0)) dutOld_i (
    .clk(clk), .rstN(rstN), .wrEn(oWrEn), .rdEn(1'b0), .addr(oAddr),
    .wrData(oWrData), .rdData(oRdData), .revIn(REV_V), .freqIn(FREQ_V),
    .scratchIn(scratchIn), .rngIn(rngIn), .cntLoIn(CLO_V), .cntHiIn(CHI_V),
    .errValid(oErrValid), .errCode(oErrCode)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    check("R9 error idle", 32'({errValid, errCode}), 32'(E_NONE));
    addr = 10'h000; #1 check("R9 guard locked", rdData, 32'h0);
    addr = 10'h070; #1 check("R9 strap reset", rdData, 32'h0000_F0C3);
    addr = 10'h014; #1 check("R9 plain word zero", rdData, 32'h0);

    // Vector table walk on the newer-mode instance
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wrEn = VEC[i].wr; addr = VEC[i].addr; wrData = VEC[i].data;
      @(negedge clk);
      wrEn = 1'b0;
      check($sformatf("R%0d vec%0d err", VEC[i].req, i),
            32'({errValid, errCode}), 32'(VEC[i].err));
      addr = VEC[i].rdAddr;
      #1 check($sformatf("R%0d vec%0d read", VEC[i].req, i), rdData, VEC[i].exp);
    end

    // R10: pulse lasts one cycle after a bad write
    @(negedge clk);
    wrEn = 1'b1; addr = 10'h0C8; wrData = 32'h1;
    @(negedge clk);
    wrEn = 1'b0;
    check("R10 pulse present", 32'({errValid, errCode}), 32'(E_RO));
    @(negedge clk);
    check("R10 pulse gone", 32'({errValid, errCode}), 32'(E_NONE));

    // R7: out-of-range read with strobe
    rdEn = 1'b1; addr = 10'h104;
    #1 check("R7 range read data", rdData, 32'h0);
    @(negedge clk);
    rdEn = 1'b0;
    check("R7 range read err", 32'({errValid, errCode}), 32'(E_RANGE));

    // R8: read-only word tracks its input with no clock edge
    addr = 10'h0C8; rngIn = 32'h0BAD_F00D;
    #1 check("R8 live read", rdData, 32'h0BAD_F00D);
    addr = 10'h0D0;
    #1 check("R8 counter low", rdData, CLO_V);

    // R6: older mode
    @(negedge clk);
    oAddr = 10'h070;
    #1 check("R6 old strap reset", oRdData, 32'h0000_F0C3);
    @(negedge clk);
    oWrEn = 1'b1; oAddr = 10'h070; oWrData = 32'h0000_0001;
    @(negedge clk);
    oWrEn = 1'b0;
    check("R6 old strap err", 32'({oErrValid, oErrCode}), 32'(E_LOCK));
    #1 check("R6 old strap replaced", oRdData, 32'h0000_0001);
    @(negedge clk);
    oWrEn = 1'b1; oAddr = 10'h07C; oWrData = 32'hFFFF_FFFF;
    @(negedge clk);
    oWrEn = 1'b0;
    check("R6 old rev err", 32'({oErrValid, oErrCode}), 32'(E_RO));
    oAddr = 10'h070;
    #1 check("R6 old strap kept", oRdData, 32'h0000_0001);
    oAddr = 10'h07C;
    #1 check("R6 old rev intact", oRdData, REV_V);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule